// File: doc/BRIEF.md
# LPC DMA End-of-Transfer Tracker

This block sits on the host side of a DMA cycle on the low pin count bus. The peripheral returns a 4-bit SYNC code with each data byte. For each of those codes the block decides three things: whether the cycle moves on to the next byte, whether the cycle ends early, and whether the internal request line toward the legacy DMA controller stays up or is released. A transfer ends only through these codes. The peripheral's own request wire plays no part in ending a transfer.

A cycle opens with a `start` strobe while a channel is granted. The strobe latches the channel, the size (one or two bytes) and the direction. Each SYNC strobe that carries a ready code completes one byte and raises `byteDone`, which tells the controller to advance its address and count. A code of 0000b or 1010b marks the final byte. When it arrives on the first byte of a 16-bit transfer, the second byte is dropped, the cycle is cut short and a protocol error is flagged. A code of 1001b keeps the request asserted once the cycle has closed. For writes, the block assembles the received bytes into a word. When only one byte was moved, it fills the upper byte with a fixed pad value.

All outputs are registered. Each one reflects the inputs sampled at the previous rising clock edge.

Top module: `lpc_dma_eot`

## Requirements
- R1: While `rstN` is low, `reqActive`, `byteDone`, `cycleDone`, `cutShort`, `errFlag` and `wordValid` are all 0.
- R2: A `start` with `grantValid` high sets `reqActive` one clock later, with `reqChan` equal to `grantChan`. A `start` while `grantValid` is low has no effect.
- R3: A SYNC strobe whose code is not 0000b, 1010b or 1001b is ignored: no pulse appears and the request level does not change. A SYNC strobe while no cycle is open is also ignored.
- R4: On a one-byte transfer, code 0000b or 1010b gives `byteDone` and `cycleDone`, drops `reqActive`, and raises neither `cutShort` nor `errFlag`.
- R5: Code 1001b on the final byte of the announced size gives `byteDone` and `cycleDone` and leaves `reqActive` high.
- R6: On a two-byte transfer, code 1001b on the first byte gives only `byteDone`. The cycle stays open for the second byte.
- R7: Code 0000b or 1010b on the first byte of a two-byte transfer gives `byteDone`, `cycleDone` and `cutShort`, sets `errFlag` and drops `reqActive`. Later SYNC strobes are ignored until the next start.
- R8: Code 0000b or 1010b on the second byte of a two-byte transfer drops `reqActive` without `cutShort` and without `errFlag`.
- R9: When a write cycle closes, `wordValid` pulses together with `cycleDone`. `wordOut` holds the second byte in bits 15:8 and the first byte in bits 7:0. If only one byte was moved, bits 15:8 hold `PAD_VALUE` (default A5h). Read cycles never pulse `wordValid`.
- R10: While `grantValid` is low, `reqActive` is 0 one clock later and any open cycle is abandoned, so later SYNC strobes are ignored.
- R11: `errFlag` stays set until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| grantValid | input | 1 | A channel is currently granted |
| grantChan | input | CHAN_W | Granted channel number |
| start | input | 1 | Opens a new cycle (wins over a SYNC strobe in the same clock) |
| wideXfer | input | 1 | 1 = two-byte transfer, 0 = one byte |
| writeXfer | input | 1 | 1 = peripheral to host, 0 = host to peripheral |
| syncValid | input | 1 | A SYNC code is present this clock |
| syncCode | input | 4 | SYNC code returned by the peripheral |
| dataIn | input | DATA_W | Byte that goes with the SYNC code |
| reqActive | output | 1 | Request level toward the DMA controller |
| reqChan | output | CHAN_W | Channel that owns the request |
| byteDone | output | 1 | One byte moved; advance address and count |
| cycleDone | output | 1 | The current cycle closed |
| cutShort | output | 1 | The cycle closed before its announced size |
| errFlag | output | 1 | Early end on the first byte of a two-byte transfer |
| wordValid | output | 1 | Write word is ready on `wordOut` |
| wordOut | output | 2*DATA_W | Assembled write word |

## Verification
The bench cuts a 16-bit read short and then sends one more 1001b strobe. A design that still ran the second byte would pulse `byteDone` again. A design that took the request line as the end signal, or that lost the flag on the idle strobe, would also get `errFlag` wrong. The bench closes an 8-bit transfer with 1001b and checks that the request stays up, which catches a design that treats every final byte as a release. It cuts a 16-bit write short and runs a one-byte write, and expects the pad byte in the upper half; a design that left stale data there fails. Dropping the grant halfway through a cycle must abandon it, and a start without a grant must not raise the request.

// File: rtl/lpc_eot_pkg.sv
package lpc_eot_pkg;
  localparam int CODE_W = 4;
  // Ready codes that end the transfer (clean and with error)
  localparam logic [CODE_W-1:0] SYNC_DONE     = 4'b0000;
  localparam logic [CODE_W-1:0] SYNC_DONE_ERR = 4'b1010;
  // Ready code that asks for more data
  localparam logic [CODE_W-1:0] SYNC_MORE     = 4'b1001;

  typedef struct packed {
    logic captureLo;
    logic captureHi;
    logic padHi;
    logic publish;
  } eot_strobe_t;
endpackage

// File: rtl/lpc_eot_ctrl.sv
module lpc_eot_ctrl
  import lpc_eot_pkg::*;
#(
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              grantValid,
  input  logic [CHAN_W-1:0] grantChan,
  input  logic              start,
  input  logic              wideXfer,
  input  logic              writeXfer,
  input  logic              syncValid,
  input  logic [CODE_W-1:0] syncCode,
  output logic              reqActive,
  output logic [CHAN_W-1:0] reqChan,
  output logic              byteDone,
  output logic              cycleDone,
  output logic              cutShort,
  output logic              errFlag,
  output eot_strobe_t       strb
);
  logic active, wideQ, writeQ, byteIdx;
  logic startOk, isTerm, isMore, evt, lastByte, closeNow, shortNow;

  always_comb begin
    startOk  = start & grantValid;
    isTerm   = (syncCode == SYNC_DONE) | (syncCode == SYNC_DONE_ERR);
    isMore   = (syncCode == SYNC_MORE);
    // A start in the same clock wins over a SYNC strobe
    evt      = active & grantValid & syncValid & ~startOk & (isTerm | isMore);
    lastByte = ~wideQ | byteIdx;
    closeNow = evt & (isTerm | lastByte);
    shortNow = evt & isTerm & ~lastByte;
    strb.captureLo = evt & ~byteIdx;
    strb.captureHi = evt & byteIdx;
    strb.padHi     = closeNow & writeQ & ~byteIdx;
    strb.publish   = closeNow & writeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      wideQ     <= 1'b0;
      writeQ    <= 1'b0;
      byteIdx   <= 1'b0;
      reqActive <= 1'b0;
      reqChan   <= '0;
      byteDone  <= 1'b0;
      cycleDone <= 1'b0;
      cutShort  <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      byteDone  <= evt;
      cycleDone <= closeNow;
      cutShort  <= shortNow;
      if (!grantValid) begin
        active    <= 1'b0;
        reqActive <= 1'b0;
      end else if (startOk) begin
        active    <= 1'b1;
        reqActive <= 1'b1;
        reqChan   <= grantChan;
        wideQ     <= wideXfer;
        writeQ    <= writeXfer;
        byteIdx   <= 1'b0;
        errFlag   <= 1'b0;
      end else if (evt) begin
        if (closeNow) active  <= 1'b0;
        else          byteIdx <= 1'b1;
        if (isTerm)   reqActive <= 1'b0;
        if (shortNow) errFlag   <= 1'b1;
      end
    end
  end

  // R5
  more_last_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evt && isMore && lastByte) |=> (reqActive && cycleDone && !cutShort));
  // R7
  short_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    shortNow |=> (cutShort && errFlag && !reqActive && cycleDone));
  // R8
  full_term_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evt && isTerm && lastByte) |=> (!reqActive && !cutShort));
  // R10
  nogrant_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |=> (!reqActive && !byteDone));
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !startOk) |=> errFlag);
  // R7
  cut_implies_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    cutShort |-> (cycleDone && byteDone));
endmodule

// File: rtl/lpc_eot_dpath.sv
module lpc_eot_dpath
  import lpc_eot_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter logic [DATA_W-1:0] PAD_VALUE = 8'hA5
) (
  input  logic                clk,
  input  logic                rstN,
  input  eot_strobe_t         strb,
  input  logic [DATA_W-1:0]   dataIn,
  output logic                wordValid,
  output logic [2*DATA_W-1:0] wordOut
);
  logic [DATA_W-1:0] loByte, hiByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loByte    <= '0;
      hiByte    <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= strb.publish;
      if (strb.captureLo) loByte <= dataIn;
      if (strb.captureHi) hiByte <= dataIn;
      else if (strb.padHi) hiByte <= PAD_VALUE;
    end
  end

  assign wordOut = {hiByte, loByte};

  // R9
  pad_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.padHi |=> (wordValid && wordOut[2*DATA_W-1:DATA_W] == PAD_VALUE));
  // R9
  lo_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.captureLo && strb.publish) |=> (wordOut[DATA_W-1:0] == $past(dataIn)));
endmodule

// File: rtl/lpc_dma_eot.sv
module lpc_dma_eot
  import lpc_eot_pkg::*;
#(
  parameter int                CHAN_W    = 3,
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] PAD_VALUE = 8'hA5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                grantValid,
  input  logic [CHAN_W-1:0]   grantChan,
  input  logic                start,
  input  logic                wideXfer,
  input  logic                writeXfer,
  input  logic                syncValid,
  input  logic [3:0]          syncCode,
  input  logic [DATA_W-1:0]   dataIn,
  output logic                reqActive,
  output logic [CHAN_W-1:0]   reqChan,
  output logic                byteDone,
  output logic                cycleDone,
  output logic                cutShort,
  output logic                errFlag,
  output logic                wordValid,
  output logic [2*DATA_W-1:0] wordOut
);
  eot_strobe_t strb;

  lpc_eot_ctrl #(.CHAN_W(CHAN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .grantValid(grantValid), .grantChan(grantChan),
    .start(start), .wideXfer(wideXfer), .writeXfer(writeXfer),
    .syncValid(syncValid), .syncCode(syncCode),
    .reqActive(reqActive), .reqChan(reqChan), .byteDone(byteDone),
    .cycleDone(cycleDone), .cutShort(cutShort), .errFlag(errFlag), .strb(strb)
  );

  lpc_eot_dpath #(.DATA_W(DATA_W), .PAD_VALUE(PAD_VALUE)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn),
    .wordValid(wordValid), .wordOut(wordOut)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!reqActive && !byteDone && !cycleDone && !cutShort && !errFlag && !wordValid));
  // R9
  word_with_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> cycleDone);
endmodule

// File: tb/lpc_dma_eot_bench.sv
module lpc_dma_eot_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] PAD = 8'hA5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic grantValid = 1'b0, start = 1'b0, wideXfer = 1'b0, writeXfer = 1'b0, syncValid = 1'b0;
  logic [2:0] grantChan = '0;
  logic [3:0] syncCode = '0;
  logic [7:0] dataIn = '0;
  logic reqActive, byteDone, cycleDone, cutShort, errFlag, wordValid;
  logic [2:0] reqChan;
  logic [15:0] wordOut;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [5:0]  flags;   // req, byteDone, cycleDone, cutShort, err, wordValid
    logic [2:0]  chan;
    logic [15:0] word;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lpc_dma_eot u_lpc_dma_eot (
    .clk(clk), .rstN(rstN), .grantValid(grantValid), .grantChan(grantChan),
    .start(start), .wideXfer(wideXfer), .writeXfer(writeXfer),
    .syncValid(syncValid), .syncCode(syncCode), .dataIn(dataIn),
    .reqActive(reqActive), .reqChan(reqChan), .byteDone(byteDone),
    .cycleDone(cycleDone), .cutShort(cutShort), .errFlag(errFlag),
    .wordValid(wordValid), .wordOut(wordOut)
  );

  // Driver: apply one clock of stimulus and queue what must follow it
  task automatic cyc(input logic st, input logic gv, input logic [2:0] ch,
                     input logic wd, input logic wr, input logic sv,
                     input logic [3:0] cd, input logic [7:0] dt,
                     input logic [5:0] eFlags, input logic [2:0] eChan,
                     input logic [15:0] eWord, input string tag);
    exp_t e;
    @(negedge clk);
    start = st; grantValid = gv; grantChan = ch; wideXfer = wd;
    writeXfer = wr; syncValid = sv; syncCode = cd; dataIn = dt;
    e.flags = eFlags; e.chan = eChan; e.word = eWord; e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: compare one clock after each stimulus, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        logic [5:0] act;
        logic bad;
        e = expQ.pop_front();
        act = {reqActive, byteDone, cycleDone, cutShort, errFlag, wordValid};
        bad = (act !== e.flags);
        if (e.flags[5] && reqChan !== e.chan) bad = 1'b1;
        if (e.flags[0] && wordOut !== e.word) bad = 1'b1;
        checks++;
        if (bad) begin
          fails++;
          $display("FAIL %s: flags=%b chan=%0d word=%h expected flags=%b chan=%0d word=%h",
                   e.tag, act, reqChan, wordOut, e.flags, e.chan, e.word);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({reqActive, byteDone, cycleDone, cutShort, errFlag, wordValid} !== 6'b0) begin
      fails++;
      $display("FAIL R1: flags=%b expected 000000",
               {reqActive, byteDone, cycleDone, cutShort, errFlag, wordValid});
    end
    rstN = 1'b1;
    // flags order: req bd cd cut err wv
    // R2 start without grant is ignored
    cyc(1,0,3'd2,0,0,0,4'h0,8'h00, 6'b000000, 0, 0, "R2 start no grant");
    cyc(0,1,3'd2,0,0,0,4'h0,8'h00, 6'b000000, 0, 0, "R2 idle");
    // R2 / R3 / R4 8-bit read ending with 0000b
    cyc(1,1,3'd2,0,0,0,4'h0,8'h00, 6'b100000, 3'd2, 0, "R2 start ch2");
    cyc(0,1,3'd2,0,0,1,4'h6,8'h00, 6'b100000, 3'd2, 0, "R3 wait code");
    cyc(0,1,3'd2,0,0,1,4'hF,8'h00, 6'b100000, 3'd2, 0, "R3 other code");
    cyc(0,1,3'd2,0,0,1,4'h0,8'h11, 6'b011000, 0, 0, "R4 8-bit done");
    // R5 8-bit read ending with 1001b keeps the request
    cyc(1,1,3'd3,0,0,0,4'h0,8'h00, 6'b100000, 3'd3, 0, "R2 start ch3");
    cyc(0,1,3'd3,0,0,1,4'h9,8'h22, 6'b111000, 3'd3, 0, "R5 more on last");
    cyc(0,1,3'd3,0,0,1,4'h0,8'h00, 6'b100000, 3'd3, 0, "R3 sync while idle");
    // R6 / R8 full 16-bit read
    cyc(1,1,3'd6,1,0,0,4'h0,8'h00, 6'b100000, 3'd6, 0, "R2 start ch6");
    cyc(0,1,3'd6,1,0,1,4'h9,8'h00, 6'b110000, 3'd6, 0, "R6 first byte more");
    cyc(0,1,3'd6,1,0,1,4'hA,8'h00, 6'b011000, 0, 0, "R8 second byte term");
    // R7 / R11 16-bit read cut short, then a stray strobe
    cyc(1,1,3'd7,1,0,0,4'h0,8'h00, 6'b100000, 3'd7, 0, "R2 start ch7");
    cyc(0,1,3'd7,1,0,1,4'h0,8'h00, 6'b011110, 0, 0, "R7 cut short");
    cyc(0,1,3'd7,1,0,1,4'h9,8'h00, 6'b000010, 0, 0, "R7 no second byte / R11");
    // R9 16-bit write, both bytes
    cyc(1,1,3'd1,1,1,0,4'h0,8'h00, 6'b100000, 3'd1, 0, "R11 start clears err");
    cyc(0,1,3'd1,1,1,1,4'h9,8'h34, 6'b110000, 3'd1, 0, "R9 write lo");
    cyc(0,1,3'd1,1,1,1,4'h9,8'h12, 6'b111001, 3'd1, 16'h1234, "R9 write word");
    // R9 / R7 16-bit write cut short gets a pad byte
    cyc(1,1,3'd1,1,1,0,4'h0,8'h00, 6'b100000, 3'd1, 0, "R2 start write");
    cyc(0,1,3'd1,1,1,1,4'hA,8'h77, 6'b011111, 0, {PAD,8'h77}, "R9 short write pad");
    // R9 8-bit write
    cyc(1,1,3'd4,0,1,0,4'h0,8'h00, 6'b100000, 3'd4, 0, "R11 start 8-bit write");
    cyc(0,1,3'd4,0,1,1,4'h0,8'h5C, 6'b011001, 0, {PAD,8'h5C}, "R9 8-bit write pad");
    // R10 grant lost mid-cycle
    cyc(1,1,3'd5,1,0,0,4'h0,8'h00, 6'b100000, 3'd5, 0, "R2 start ch5");
    cyc(0,1,3'd5,1,0,1,4'h9,8'h00, 6'b110000, 3'd5, 0, "R6 first byte");
    cyc(0,0,3'd5,1,0,0,4'h0,8'h00, 6'b000000, 0, 0, "R10 grant dropped");
    cyc(0,1,3'd5,1,0,1,4'h0,8'h00, 6'b000000, 0, 0, "R10 cycle abandoned");
    cyc(1,0,3'd5,0,0,0,4'h0,8'h00, 6'b000000, 0, 0, "R10 start without grant");
    cyc(0,1,3'd0,0,0,0,4'h0,8'h00, 6'b000000, 0, 0, "R2 still idle");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule